// File: doc/BRIEF.md
# Serial Character Receiver with Per-Word Error Flags

This block turns an idle-high asynchronous serial line into parallel characters. A separate generator supplies a one-cycle enable pulse at sixteen times the bit rate. The receiver uses this pulse to confirm a start bit at its midpoint. It then collects 5 to 8 data bits, least significant bit first. An optional parity bit follows, and then one or two stop bits.

Each finished character goes to the write port of a receive FIFO as one word. The word holds the data and four status flags: parity error, framing error, line break, and overrun. The FIFO storage sits outside this block. Only its full indication comes back in.

The character shape comes from static configuration inputs: length, parity on/off, parity sense and stop count. The surrounding logic must hold these inputs steady while a character is arriving.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `fifoWrite` is low and `fifoData` and all four status outputs are zero. No word is written while the line stays high.
- R2: A low level on the line is taken as a start bit only if it is still low at the eighth 16x tick after it was first seen. A low pulse of four ticks or fewer produces no word.
- R3: `wordLen` selects the character length: 0=5, 1=6, 2=7, 3=8 bits. Bits are received least significant first and each is sampled 16 ticks after the previous sample. The word appears right-aligned in `fifoData` with all bits above the length set to zero.
- R4: When `parityOn`=1, one parity bit follows the data. `parityOdd`=0 expects an even number of ones across the data and parity bit, and `parityOdd`=1 expects an odd number. A mismatch sets `fifoParityErr`. When `parityOn`=0 there is no parity slot and `fifoParityErr` is always 0.
- R5: `twoStop`=0 means one stop bit. In that case a new start bit directly after it is received correctly. `twoStop`=1 means two stop bits, and only the first is checked: a low second stop bit raises no flag.
- R6: If the first stop bit samples low, `fifoFrameErr` is set. The data of that word is still delivered.
- R7: If every data, parity and first-stop sample is low, `fifoBreak`=1 and `fifoFrameErr`=1 and `fifoData`=0. After a word whose stop bit sampled low, a new start is accepted only after the line has returned high, so a long low level yields exactly one word.
- R8: If `fifoFull` is high when a character completes, that character is dropped and nothing is written. The next word that is written carries `fifoOverrun`=1, and later words carry 0.
- R9: `fifoWrite` is a single-cycle pulse per character. It is never asserted in the cycle after a cycle in which `fifoFull` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| wordLen | input | 2 | Character length code (0..3 = 5..8 bits) |
| parityOn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| twoStop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| fifoFull | input | 1 | Receive FIFO cannot accept a word |
| fifoWrite | output | 1 | Write strobe to the FIFO |
| fifoData | output | 8 | Received character, right-aligned |
| fifoOverrun | output | 1 | A character was dropped before this one |
| fifoParityErr | output | 1 | Parity mismatch on this character |
| fifoFrameErr | output | 1 | First stop bit was low |
| fifoBreak | output | 1 | Entire frame sampled low |

## Verification
The assertions check, on every cycle, the properties that can be judged at the write port alone:
- the write strobe lasts one cycle and is never raised right after a full cycle;
- a break word also carries a framing error and zero data;
- no parity error appears with parity off;
- no bit above the selected length is set.

Whether the right bits were sampled at the right moments can only be shown by the bench's scenarios. These cover:
- start-glitch rejection;
- bit order and each length;
- both parity senses;
- stop-bit handling;
- the single word produced by a long break;
- the overrun flag landing on the next accepted word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2,
    ST_DONE,
    ST_RECOVER
  } rxState_e;

  typedef struct packed {
    logic clear;
    logic shiftEn;
    logic sampleParity;
    logic sampleStop1;
    logic finish;
  } rxStrobes_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8,
  parameter int MIN_LEN    = 5,
  parameter int LEN_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             rxBit,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityOn,
  input  logic             twoStop,
  output rxStrobes_t       stb
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  rxState_e          state, nextState;
  logic [CNT_W-1:0]  cnt, nextCnt;
  logic [IDX_W-1:0]  bitIdx, nextIdx;
  logic [IDX_W-1:0]  lastIdx;

  assign lastIdx = IDX_W'(wordLen) + IDX_W'(MIN_LEN - 1);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextCnt   = cnt;
    nextIdx   = bitIdx;
    unique case (state)
      ST_IDLE: begin
        if (tick16 && !rxBit) begin
          nextState = ST_START;
          nextCnt   = '0;
        end
      end
      ST_START: begin
        if (tick16) begin
          if (cnt == MID) begin
            nextCnt = '0;
            if (!rxBit) begin
              nextState = ST_DATA;
              nextIdx   = '0;
              stb.clear = 1'b1;
            end else begin
              nextState = ST_IDLE;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick16) begin
          if (cnt == LAST) begin
            nextCnt     = '0;
            stb.shiftEn = 1'b1;
            if (bitIdx == lastIdx) nextState = parityOn ? ST_PARITY : ST_STOP1;
            else                   nextIdx   = bitIdx + 1'b1;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (tick16) begin
          if (cnt == LAST) begin
            nextCnt          = '0;
            stb.sampleParity = 1'b1;
            nextState        = ST_STOP1;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
      end
      ST_STOP1: begin
        if (tick16) begin
          if (cnt == LAST) begin
            nextCnt         = '0;
            stb.sampleStop1 = 1'b1;
            nextState       = twoStop ? ST_STOP2 : ST_DONE;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (tick16) begin
          if (cnt == LAST) begin
            nextCnt   = '0;
            nextState = ST_DONE;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
      end
      ST_DONE: begin
        stb.finish = 1'b1;
        nextState  = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (rxBit) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextIdx;
    end
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX = 8,
  parameter int MIN_LEN  = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxBit,
  input  rxStrobes_t          stb,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityOdd,
  input  logic                fifoFull,
  output logic                fifoWrite,
  output logic [DATA_MAX-1:0] fifoData,
  output logic                fifoOverrun,
  output logic                fifoParityErr,
  output logic                fifoFrameErr,
  output logic                fifoBreak
);
  localparam int SH_W = $clog2(DATA_MAX) + 1;

  logic [DATA_MAX-1:0] shreg;
  logic                parAcc;
  logic                anyHigh;
  logic                parErr;
  logic                frameErr;
  logic                ovPend;
  logic [SH_W-1:0]     alignShift;
  logic [DATA_MAX-1:0] aligned;

  assign alignShift = SH_W'(DATA_MAX - MIN_LEN) - SH_W'(wordLen);
  assign aligned    = shreg >> alignShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg         <= '0;
      parAcc        <= 1'b0;
      anyHigh       <= 1'b0;
      parErr        <= 1'b0;
      frameErr      <= 1'b0;
      ovPend        <= 1'b0;
      fifoWrite     <= 1'b0;
      fifoData      <= '0;
      fifoOverrun   <= 1'b0;
      fifoParityErr <= 1'b0;
      fifoFrameErr  <= 1'b0;
      fifoBreak     <= 1'b0;
    end else begin
      fifoWrite <= 1'b0;
      if (stb.clear) begin
        shreg    <= '0;
        parAcc   <= 1'b0;
        anyHigh  <= 1'b0;
        parErr   <= 1'b0;
        frameErr <= 1'b0;
      end
      if (stb.shiftEn) begin
        shreg   <= {rxBit, shreg[DATA_MAX-1:1]};
        parAcc  <= parAcc ^ rxBit;
        anyHigh <= anyHigh | rxBit;
      end
      if (stb.sampleParity) begin
        parErr  <= parAcc ^ rxBit ^ parityOdd;
        anyHigh <= anyHigh | rxBit;
      end
      if (stb.sampleStop1) begin
        frameErr <= ~rxBit;
        anyHigh  <= anyHigh | rxBit;
      end
      if (stb.finish) begin
        if (fifoFull) begin
          ovPend <= 1'b1;
        end else begin
          fifoWrite     <= 1'b1;
          fifoData      <= aligned;
          fifoOverrun   <= ovPend;
          fifoParityErr <= parErr;
          fifoFrameErr  <= frameErr;
          fifoBreak     <= ~anyHigh;
          ovPend        <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_MAX    = 8,
  parameter int MIN_LEN     = 5,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxLine,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityOn,
  input  logic                parityOdd,
  input  logic                twoStop,
  input  logic                fifoFull,
  output logic                fifoWrite,
  output logic [DATA_MAX-1:0] fifoData,
  output logic                fifoOverrun,
  output logic                fifoParityErr,
  output logic                fifoFrameErr,
  output logic                fifoBreak
);
  logic       rxBit;
  rxStrobes_t stb;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rxLine),
    .dout(rxBit)
  );

  uart_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_MAX  (DATA_MAX),
    .MIN_LEN   (MIN_LEN),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick16  (tick16),
    .rxBit   (rxBit),
    .wordLen (wordLen),
    .parityOn(parityOn),
    .twoStop (twoStop),
    .stb     (stb)
  );

  uart_rx_dpath #(
    .DATA_MAX(DATA_MAX),
    .MIN_LEN (MIN_LEN),
    .LEN_W   (LEN_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .rxBit        (rxBit),
    .stb          (stb),
    .wordLen      (wordLen),
    .parityOdd    (parityOdd),
    .fifoFull     (fifoFull),
    .fifoWrite    (fifoWrite),
    .fifoData     (fifoData),
    .fifoOverrun  (fifoOverrun),
    .fifoParityErr(fifoParityErr),
    .fifoFrameErr (fifoFrameErr),
    .fifoBreak    (fifoBreak)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_MAX = 8,
  parameter int MIN_LEN  = 5,
  parameter int LEN_W    = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick16,
  input logic                rxLine,
  input logic [LEN_W-1:0]    wordLen,
  input logic                parityOn,
  input logic                parityOdd,
  input logic                twoStop,
  input logic                fifoFull,
  input logic                fifoWrite,
  input logic [DATA_MAX-1:0] fifoData,
  input logic                fifoOverrun,
  input logic                fifoParityErr,
  input logic                fifoFrameErr,
  input logic                fifoBreak
);
  logic seenEdge;
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assert_write_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |=> !fifoWrite);

  assert_no_write_after_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && fifoWrite) |-> !$past(fifoFull));

  assert_break_is_frame_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrite && fifoBreak) |-> (fifoFrameErr && fifoData == '0));

  assert_no_parity_err_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrite && !parityOn) |-> !fifoParityErr);

  assert_upper_bits_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |-> ((32'(fifoData) >> (32'(wordLen) + MIN_LEN)) == 0));

  logic unusedIns;
  assign unusedIns = ^{tick16, rxLine, parityOdd, twoStop, fifoOverrun};
endmodule

bind uart_rx_status uart_rx_status_chk #(
  .DATA_MAX(DATA_MAX),
  .MIN_LEN (MIN_LEN),
  .LEN_W   (LEN_W)
) u_chk (.*);

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;
  localparam int TICK_CLKS = 4;
  localparam int BIT_CLKS  = 16 * TICK_CLKS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       fifoFull = 1'b0;
  logic       fifoWrite;
  logic [7:0] fifoData;
  logic       fifoOverrun, fifoParityErr, fifoFrameErr, fifoBreak;

  int checks = 0;
  int failures = 0;
  int capCount = 0;
  logic [7:0] capData;
  logic capOv, capPe, capFe, capBr;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_status u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .wordLen(wordLen), .parityOn(parityOn), .parityOdd(parityOdd),
    .twoStop(twoStop), .fifoFull(fifoFull), .fifoWrite(fifoWrite),
    .fifoData(fifoData), .fifoOverrun(fifoOverrun),
    .fifoParityErr(fifoParityErr), .fifoFrameErr(fifoFrameErr),
    .fifoBreak(fifoBreak)
  );

  initial begin
    forever begin
      repeat (TICK_CLKS - 1) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (fifoWrite) begin
      capCount = capCount + 1;
      capData  = fifoData;
      capOv    = fifoOverrun;
      capPe    = fifoParityErr;
      capFe    = fifoFrameErr;
      capBr    = fifoBreak;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic holdLine(input logic v, input int bits);
    rxLine = v;
    repeat (bits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int len, input bit parEn,
                           input bit parBit, input bit stop1, input bit useStop2,
                           input bit stop2);
    holdLine(1'b0, 1);
    for (int i = 0; i < len; i++) holdLine(d[i], 1);
    if (parEn) holdLine(parBit, 1);
    holdLine(stop1, 1);
    if (useStop2) holdLine(stop2, 1);
    rxLine = 1'b1;
  endtask

  function automatic bit evenPar(input logic [7:0] d, input int len);
    bit p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  task automatic expectWord(input string req, input int cnt0, input logic [7:0] d,
                            input bit ov, input bit pe, input bit fe, input bit br);
    holdLine(1'b1, 2);
    check({req, " count"}, capCount, cnt0 + 1);
    check({req, " data"}, capData, d);
    check({req, " overrun"}, capOv, ov);
    check({req, " parity"}, capPe, pe);
    check({req, " frame"}, capFe, fe);
    check({req, " break"}, capBr, br);
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    holdLine(1'b1, 3);
    check("R1 write", fifoWrite, 0);
    check("R1 data", fifoData, 0);
    check("R1 flags", {fifoOverrun, fifoParityErr, fifoFrameErr, fifoBreak}, 0);
    check("R1 no word", capCount, 0);
  endtask

  task automatic testEightBit();
    int c;
    wordLen = 2'd3; parityOn = 1'b0; twoStop = 1'b0;
    c = capCount; sendFrame(8'hA5, 8, 0, 0, 1, 0, 0); expectWord("R3 8bit A5", c, 8'hA5, 0, 0, 0, 0);
    c = capCount; sendFrame(8'h3C, 8, 0, 0, 1, 0, 0); expectWord("R3 8bit 3C", c, 8'h3C, 0, 0, 0, 0);
  endtask

  task automatic testShortLengths();
    int c;
    parityOn = 1'b0;
    wordLen = 2'd0; c = capCount; sendFrame(8'h15, 5, 0, 0, 1, 0, 0); expectWord("R3 5bit", c, 8'h15, 0, 0, 0, 0);
    wordLen = 2'd1; c = capCount; sendFrame(8'h2B, 6, 0, 0, 1, 0, 0); expectWord("R3 6bit", c, 8'h2B, 0, 0, 0, 0);
    wordLen = 2'd2; c = capCount; sendFrame(8'h7F, 7, 0, 0, 1, 0, 0); expectWord("R3 7bit", c, 8'h7F, 0, 0, 0, 0);
    wordLen = 2'd3;
  endtask

  task automatic testParity();
    int c;
    wordLen = 2'd3; parityOn = 1'b1;
    parityOdd = 1'b0;
    c = capCount; sendFrame(8'h17, 8, 1, evenPar(8'h17, 8), 1, 0, 0);
    expectWord("R4 even ok", c, 8'h17, 0, 0, 0, 0);
    c = capCount; sendFrame(8'h17, 8, 1, ~evenPar(8'h17, 8), 1, 0, 0);
    expectWord("R4 even bad", c, 8'h17, 0, 1, 0, 0);
    parityOdd = 1'b1;
    c = capCount; sendFrame(8'hC3, 8, 1, ~evenPar(8'hC3, 8), 1, 0, 0);
    expectWord("R4 odd ok", c, 8'hC3, 0, 0, 0, 0);
    c = capCount; sendFrame(8'hC3, 8, 1, evenPar(8'hC3, 8), 1, 0, 0);
    expectWord("R4 odd bad", c, 8'hC3, 0, 1, 0, 0);
    parityOn = 1'b0; parityOdd = 1'b0;
    c = capCount; sendFrame(8'h01, 8, 0, 0, 1, 0, 0);
    expectWord("R4 parity off", c, 8'h01, 0, 0, 0, 0);
  endtask

  task automatic testStops();
    int c;
    wordLen = 2'd3; parityOn = 1'b0;
    twoStop = 1'b1;
    c = capCount; sendFrame(8'h5A, 8, 0, 0, 1, 1, 0);
    expectWord("R5 second stop low", c, 8'h5A, 0, 0, 0, 0);
    twoStop = 1'b0;
    c = capCount;
    sendFrame(8'h81, 8, 0, 0, 1, 0, 0);
    sendFrame(8'h42, 8, 0, 0, 1, 0, 0);
    holdLine(1'b1, 2);
    check("R5 back-to-back count", capCount, c + 2);
    check("R5 back-to-back data", capData, 8'h42);
  endtask

  task automatic testFraming();
    int c;
    wordLen = 2'd3; parityOn = 1'b0; twoStop = 1'b0;
    c = capCount; sendFrame(8'h96, 8, 0, 0, 0, 0, 0);
    expectWord("R6 frame err", c, 8'h96, 0, 0, 1, 0);
  endtask

  task automatic testGlitch();
    int c;
    c = capCount;
    rxLine = 1'b0;
    repeat (4 * TICK_CLKS) @(negedge clk);
    holdLine(1'b1, 3);
    check("R2 glitch rejected", capCount, c);
  endtask

  task automatic testBreak();
    int c;
    wordLen = 2'd3; parityOn = 1'b1; parityOdd = 1'b0; twoStop = 1'b0;
    c = capCount;
    holdLine(1'b0, 14);
    expectWord("R7 break", c, 8'h00, 0, 0, 1, 1);
    parityOn = 1'b0;
  endtask

  task automatic testOverrun();
    int c;
    wordLen = 2'd3; parityOn = 1'b0; twoStop = 1'b0;
    c = capCount;
    fifoFull = 1'b1;
    sendFrame(8'h11, 8, 0, 0, 1, 0, 0);
    holdLine(1'b1, 2);
    check("R8 dropped while full", capCount, c);
    fifoFull = 1'b0;
    c = capCount; sendFrame(8'h22, 8, 0, 0, 1, 0, 0);
    expectWord("R8 overrun flagged", c, 8'h22, 1, 0, 0, 0);
    c = capCount; sendFrame(8'h33, 8, 0, 0, 1, 0, 0);
    expectWord("R8 overrun cleared", c, 8'h33, 0, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testEightBit();
    testShortLengths();
    testParity();
    testStops();
    testFraming();
    testGlitch();
    testBreak();
    testOverrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule